// File: doc/BRIEF.md
# Next-PC and Link Unit

This unit decides where instruction fetch goes next and what return address a call saves. It is purely combinational. The inputs are the current program counter, two register operands, an offset that decode has already sign-extended, an operation code and a flag that marks a 2-byte instruction. The outputs are the next program counter, a link value, a link-write enable and a taken flag.

It covers straight-line flow, direct jumps with or without link, register jumps with or without link, six two-operand branch conditions and two zero-test branches. It handles both 4-byte and 2-byte instruction lengths. Instruction decode, selection of the link destination register and the register file belong to neighbouring blocks.

Top module: `nxpc_unit`

## Requirements
- R1: With op code 0 (sequential), next_pc is pc+4, or pc+2 when compressed is high. link_we and taken are both 0.
- R2: With op code 1 (direct jump with link), next_pc is pc + offset*2 and taken is 1. link_we is 1 and link_val is pc+4, or pc+2 when compressed. link_val always carries pc plus the instruction length.
- R3: With op code 2 (direct jump without link), next_pc is pc + offset*2, taken is 1 and link_we is 0.
- R4: Op code 3 (register jump with link) and op code 4 (register jump without link) both set next_pc to (op_a + offset) with bit 0 forced to 0, and set taken to 1. link_we is 1 only for op code 3.
- R5: Op code 5 takes the branch when op_a equals op_b. Op code 6 takes it when they differ. A taken branch sets next_pc to pc + offset*2 and taken to 1.
- R6: Op code 7 takes the branch when op_a < op_b as signed two's-complement values. Op code 8 takes it when op_a >= op_b as signed values.
- R7: Op code 9 takes the branch when op_a < op_b as unsigned values. Op code 10 takes it when op_a >= op_b as unsigned values.
- R8: A branch that is not taken sets next_pc to pc+4 (pc+2 when compressed), taken to 0 and link_we to 0.
- R9: Op code 11 takes the branch when op_a is zero. Op code 12 takes it when op_a is non-zero. op_b has no effect on either.
- R10: All address sums wrap modulo 2^32.
- R11: Op codes 13 to 15 behave like op code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 32 | Address of the current instruction |
| op_a | input | 32 | First register operand, also the register-jump base |
| op_b | input | 32 | Second register operand |
| offset | input | 32 | Sign-extended offset: counted in halfwords for direct jumps and branches, in bytes for register jumps |
| op | input | 4 | Flow operation code |
| compressed | input | 1 | High for a 2-byte instruction |
| next_pc | output | 32 | Address of the next instruction |
| link_val | output | 32 | Return address (pc plus instruction length) |
| link_we | output | 1 | Link value must be written |
| taken | output | 1 | Flow leaves the sequential path |

## Verification
The unit has no register, so every result is due in the same cycle that its inputs change: zero clock edges of latency. The bench applies each stimulus just after a falling clock edge. It samples all four outputs 2 ns later, well before the next rising edge, so every comparison sees settled logic and no result depends on the order of processes at an edge. Corner cases include a register-jump base with bit 0 set, operands that compare differently as signed and as unsigned, a zero-test branch with op_b non-zero, and sums that cross 2^32.

// File: rtl/nxpc_pkg.sv
// Package: types shared by the next-PC unit and its checker.
// Assumes op codes 13..15 are unused and treated as sequential.
package nxpc_pkg;
    typedef enum logic [3:0] {
        NX_SEQ  = 4'd0,
        NX_JAL  = 4'd1,
        NX_JMP  = 4'd2,
        NX_JALR = 4'd3,
        NX_JR   = 4'd4,
        NX_BEQ  = 4'd5,
        NX_BNE  = 4'd6,
        NX_BLT  = 4'd7,
        NX_BGE  = 4'd8,
        NX_BLTU = 4'd9,
        NX_BGEU = 4'd10,
        NX_BEQZ = 4'd11,
        NX_BNEZ = 4'd12
    } nx_op_e;
endpackage

// File: rtl/nxpc_cond.sv
// Branch condition evaluator. Produces the take decision for every branch op
// code. Assumes op is one of the branch codes whenever take_o is used.
// SHARED_SUB selects one subtractor for both signed and unsigned less-than,
// or two separate comparators.
module nxpc_cond
    import nxpc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter bit SHARED_SUB = 1'b1
) (
    input  nx_op_e            op_i,
    input  logic [XLEN-1:0]   a_i,
    input  logic [XLEN-1:0]   b_i,
    output logic              take_o
);
    logic            is_signed;
    logic            equal;
    logic            less;

    // Signedness of the relational compare follows the op code.
    always_comb begin
        is_signed = (op_i == NX_BLT) || (op_i == NX_BGE);
    end

    // Equality shares one comparator across two-operand and zero-test ops.
    always_comb begin
        if (op_i == NX_BEQZ || op_i == NX_BNEZ)
            equal = (a_i == '0);
        else
            equal = (a_i == b_i);
    end

    generate
        if (SHARED_SUB) begin : g_shared
            logic [XLEN:0] diff;
            // One widened subtract; the extension bit picks signed or unsigned.
            always_comb begin
                diff = {is_signed & a_i[XLEN-1], a_i} - {is_signed & b_i[XLEN-1], b_i};
                less = diff[XLEN];
            end
        end else begin : g_split
            // Two dedicated comparators, chosen after the fact.
            always_comb begin
                if (is_signed)
                    less = $signed(a_i) < $signed(b_i);
                else
                    less = a_i < b_i;
            end
        end
    endgenerate

    // Map the comparison results onto each branch kind.
    always_comb begin
        unique case (op_i)
            NX_BEQ, NX_BEQZ:   take_o = equal;
            NX_BNE, NX_BNEZ:   take_o = ~equal;
            NX_BLT, NX_BLTU:   take_o = less;
            NX_BGE, NX_BGEU:   take_o = ~less;
            default:           take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/nxpc_addr.sv
// Address adders: sequential successor, pc-relative target and register target.
// All sums wrap at 2^XLEN. The pc-relative offset is in halfwords, the register
// offset in bytes.
module nxpc_addr #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] off_i,
    input  logic            short_i,
    output logic [XLEN-1:0] seq_o,
    output logic [XLEN-1:0] rel_o,
    output logic [XLEN-1:0] reg_o
);
    localparam logic [XLEN-1:0] STEP_FULL  = XLEN'(4);
    localparam logic [XLEN-1:0] STEP_SHORT = XLEN'(2);

    // Successor address from instruction length.
    always_comb begin
        seq_o = pc_i + (short_i ? STEP_SHORT : STEP_FULL);
    end

    // Pc-relative target, offset scaled to bytes.
    always_comb begin
        rel_o = pc_i + {off_i[XLEN-2:0], 1'b0};
    end

    // Register target with the lowest bit cleared.
    always_comb begin
        reg_o = (base_i + off_i) & ~XLEN'(1);
    end
endmodule

// File: rtl/nxpc_unit.sv
// Top of the next-PC and link unit. Combinational: classifies the op code,
// picks a target from the address adders and the condition evaluator, and
// produces the link controls. Assumes decode supplies a sign-extended offset.
module nxpc_unit
    import nxpc_pkg::*;
(
    input  logic [31:0] pc,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic [31:0] offset,
    input  logic [3:0]  op,
    input  logic        compressed,
    output logic [31:0] next_pc,
    output logic [31:0] link_val,
    output logic        link_we,
    output logic        taken
);
    localparam int XLEN = 32;

    nx_op_e          op_e;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_pc;
    logic [XLEN-1:0] reg_pc;
    logic            cond_take;
    logic            is_direct;
    logic            is_regjmp;
    logic            is_branch;

    // Cast the raw code to the enum; unused codes fall to default paths.
    always_comb begin
        op_e = nx_op_e'(op);
    end

    nxpc_addr #(.XLEN(XLEN)) addr_i (
        .pc_i    (pc),
        .base_i  (op_a),
        .off_i   (offset),
        .short_i (compressed),
        .seq_o   (seq_pc),
        .rel_o   (rel_pc),
        .reg_o   (reg_pc)
    );

    nxpc_cond #(.XLEN(XLEN), .SHARED_SUB(1'b1)) cond_i (
        .op_i   (op_e),
        .a_i    (op_a),
        .b_i    (op_b),
        .take_o (cond_take)
    );

    // Classify the operation into flow families.
    always_comb begin
        is_direct = (op_e == NX_JAL)  || (op_e == NX_JMP);
        is_regjmp = (op_e == NX_JALR) || (op_e == NX_JR);
        is_branch = (op >= 4'd5) && (op <= 4'd12);
    end

    // Choose the next address and the control flags.
    always_comb begin
        link_val = seq_pc;
        link_we  = (op_e == NX_JAL) || (op_e == NX_JALR);
        taken    = is_direct || is_regjmp || (is_branch && cond_take);
        if (is_regjmp)
            next_pc = reg_pc;
        else if (taken)
            next_pc = rel_pc;
        else
            next_pc = seq_pc;
    end
endmodule

// File: rtl/nxpc_unit_chk.sv
// Checker for nxpc_unit: relates outputs to inputs with immediate assertions,
// skipped while any input is unknown.
module nxpc_unit_chk (
    input  logic [31:0] pc,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic [31:0] offset,
    input  logic [3:0]  op,
    input  logic        compressed,
    input  logic [31:0] next_pc,
    input  logic [31:0] link_val,
    input  logic        link_we,
    input  logic        taken
);
    logic [31:0] step;

    // Instruction length in bytes.
    always_comb begin
        step = compressed ? 32'd2 : 32'd4;
    end

    // Output relations checked whenever the inputs are known.
    always_comb begin
        if (!$isunknown({pc, op_a, op_b, offset, op, compressed})) begin
            assert_fallthrough_R8: assert (taken || next_pc == pc + step);
            assert_link_value_R2: assert (link_val == pc + step);
            assert_link_needs_jump_R2: assert (!link_we || taken);
            assert_reg_align_R4: assert (!(op == 4'd3 || op == 4'd4) || next_pc[0] == 1'b0);
            assert_zero_test_R9: assert (op != 4'd11 || taken == (op_a == 32'd0));
            assert_unused_seq_R11: assert (op < 4'd13 || (!taken && !link_we));
        end
    end
endmodule

bind nxpc_unit nxpc_unit_chk chk_i (
    .pc(pc), .op_a(op_a), .op_b(op_b), .offset(offset), .op(op),
    .compressed(compressed), .next_pc(next_pc), .link_val(link_val),
    .link_we(link_we), .taken(taken)
);

// File: tb/nxpc_unit_tb_top.sv
// Directed bench for nxpc_unit: one task per scenario, outputs sampled 2 ns
// after inputs change (zero-cycle latency).
module nxpc_unit_tb_top;
    logic        clk = 1'b0;
    logic [31:0] pc, op_a, op_b, offset;
    logic [3:0]  op;
    logic        compressed;
    logic [31:0] next_pc, link_val;
    logic        link_we, taken;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    nxpc_unit dut_i (
        .pc(pc), .op_a(op_a), .op_b(op_b), .offset(offset), .op(op),
        .compressed(compressed), .next_pc(next_pc), .link_val(link_val),
        .link_we(link_we), .taken(taken)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] o, input logic [31:0] p, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] f, input logic c);
        @(negedge clk);
        op = o; pc = p; op_a = a; op_b = b; offset = f; compressed = c;
        #2;
    endtask

    task automatic t_sequential();
        drive(4'd0, 32'h1000, 32'h5, 32'h5, 32'h40, 1'b0);
        chk("R1 next", next_pc, 32'h1004);
        chk("R1 we", {31'd0, link_we}, 32'd0);
        chk("R1 taken", {31'd0, taken}, 32'd0);
        drive(4'd0, 32'h1000, 32'h5, 32'h5, 32'h40, 1'b1);
        chk("R1 next short", next_pc, 32'h1002);
    endtask

    task automatic t_direct();
        drive(4'd1, 32'h2000, 32'h0, 32'h0, -32'sd8, 1'b0);
        chk("R2 next", next_pc, 32'h1FF0);
        chk("R2 link", link_val, 32'h2004);
        chk("R2 we", {31'd0, link_we}, 32'd1);
        chk("R2 taken", {31'd0, taken}, 32'd1);
        drive(4'd1, 32'h2000, 32'h0, 32'h0, 32'd3, 1'b1);
        chk("R2 link short", link_val, 32'h2002);
        chk("R2 next short", next_pc, 32'h2006);
        drive(4'd2, 32'h2000, 32'h0, 32'h0, 32'h100, 1'b1);
        chk("R3 next", next_pc, 32'h2200);
        chk("R3 we", {31'd0, link_we}, 32'd0);
        chk("R3 taken", {31'd0, taken}, 32'd1);
    endtask

    task automatic t_register();
        drive(4'd3, 32'h8000, 32'h3001, 32'h0, 32'd4, 1'b0);
        chk("R4 next", next_pc, 32'h3004);
        chk("R4 we", {31'd0, link_we}, 32'd1);
        chk("R4 link", link_val, 32'h8004);
        drive(4'd4, 32'h8000, 32'h10, 32'h0, 32'hFFFF_FFFF, 1'b1);
        chk("R4 next neg", next_pc, 32'hE);
        chk("R4 we jr", {31'd0, link_we}, 32'd0);
        chk("R4 taken jr", {31'd0, taken}, 32'd1);
    endtask

    task automatic t_branch(input string req, input logic [3:0] o, input logic [31:0] a,
                            input logic [31:0] b, input logic exp_take, input logic c);
        logic [31:0] exp_pc;
        exp_pc = exp_take ? 32'h4000 + 32'h20 : 32'h4000 + (c ? 32'd2 : 32'd4);
        drive(o, 32'h4000, a, b, 32'h10, c);
        chk(req, {31'd0, taken}, {31'd0, exp_take});
        chk(req, next_pc, exp_pc);
        chk(req, {31'd0, link_we}, 32'd0);
    endtask

    task automatic t_branches();
        t_branch("R5 beq eq", 4'd5, 32'd7, 32'd7, 1'b1, 1'b0);
        t_branch("R5 beq ne R8", 4'd5, 32'd7, 32'd8, 1'b0, 1'b0);
        t_branch("R5 bne", 4'd6, 32'd7, 32'd8, 1'b1, 1'b0);
        t_branch("R6 blt", 4'd7, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b0);
        t_branch("R6 bge R8", 4'd8, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1);
        t_branch("R6 bge eq", 4'd8, 32'd1, 32'd1, 1'b1, 1'b0);
        t_branch("R7 bltu R8", 4'd9, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0);
        t_branch("R7 bgeu", 4'd10, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b0);
        t_branch("R7 bltu small", 4'd9, 32'd1, 32'h8000_0000, 1'b1, 1'b0);
        t_branch("R9 beqz", 4'd11, 32'd0, 32'd5, 1'b1, 1'b1);
        t_branch("R9 bnez b ignored R8", 4'd12, 32'd0, 32'd5, 1'b0, 1'b1);
        t_branch("R9 bnez", 4'd12, 32'd9, 32'd9, 1'b1, 1'b1);
    endtask

    task automatic t_wrap();
        drive(4'd0, 32'hFFFF_FFFE, 32'h0, 32'h0, 32'h0, 1'b1);
        chk("R10 seq wrap", next_pc, 32'h0);
        drive(4'd1, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h10, 1'b0);
        chk("R10 rel wrap", next_pc, 32'h1C);
        chk("R10 link wrap", link_val, 32'h0);
        drive(4'd3, 32'h0, 32'hFFFF_FFF0, 32'h0, 32'h21, 1'b0);
        chk("R10 reg wrap", next_pc, 32'h10);
    endtask

    task automatic t_unused();
        for (int k = 13; k < 16; k++) begin
            drive(4'(k), 32'h6000, 32'h0, 32'h0, 32'h80, 1'b0);
            chk("R11 next", next_pc, 32'h6004);
            chk("R11 flags", {30'd0, link_we, taken}, 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_sequential();
        t_direct();
        t_register();
        t_branches();
        t_wrap();
        t_unused();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule